// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Register

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. A host writes each channel's 12-bit code through an 8-bit data port in two pieces: a low byte and a high nibble. Each piece goes into that channel's input register. A separate transfer strobe then copies both channels' input registers into their output code registers in the same cycle. The outputs that drive the converter cells therefore change together.

All host controls are active low: select, write, transfer and clear. A mode input chooses where a clear leaves the outputs, either zero for a unipolar range or mid-scale for a bipolar range. The block runs in one clock domain. Every host pin passes through a two-stage synchronizer, and each register updates on every cycle in which its synchronized enable holds. This stands in for level-sensitive latches while keeping the design flip-flop based.

Top module: `dac_pair_frontend`

## Requirements
- R1: After `rst_n` is asserted, both 12-bit codes on `dac_codes` read 000 hex.
- R2: With select and write low and `port_addr[0]`=0, `port_data[7:0]` is stored into bits 7..0 of one channel's input register. `port_addr[1]`=0 picks channel A, which drives `dac_codes[11:0]`. `port_addr[1]`=1 picks channel B, which drives `dac_codes[23:12]`.
- R3: With select and write low and `port_addr[0]`=1, `port_data[3:0]` is stored into bits 11..8 of the addressed channel's input register. `port_data[7:4]` has no effect.
- R4: A write while the transfer strobe is high leaves `dac_codes` unchanged.
- R5: With select and transfer low, both channels' code registers take their input-register contents in the same cycle.
- R6: With select, write and transfer all low, the written data reaches the addressed channel's output code directly.
- R7: While select is high, write and transfer lows change no register. A later transfer shows the input registers unchanged.
- R8: A clear with `bip_mode`=0 forces every input register and every output code to 000 hex.
- R9: A clear with `bip_mode`=1 forces the input registers to 000 hex and both output codes to 800 hex. The outputs hold 800 hex after the clear is released until a transfer.
- R10: Clear takes priority over select, write and transfer held low at the same time.
- R11: A transfer after a clear moves 000 hex into both output codes.
- R12: A change on a host pin appears on `dac_codes` at the third rising clock edge after it, and not before. The first two edges go to the synchronizer and the third to the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_data | input | 8 | Host data byte |
| port_addr | input | 2 | Bit 0: 0 = low byte, 1 = high nibble. Bit 1: channel (0 = A, 1 = B) |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low input-register write |
| ld_n | input | 1 | Active-low transfer to the output code registers |
| clr_n | input | 1 | Active-low clear, highest priority |
| bip_mode | input | 1 | Clear target: 0 = zero, 1 = mid-scale |
| dac_codes | output | 24 | Channel A code in bits 11..0, channel B code in bits 23..12 |

## Verification
The assertions watch, on every cycle, the relation between the synchronized controls and the codes one edge later. They check the mode-dependent clear value, the hold when select is high or only a write is active, and the direct pass-through of a low byte or high nibble when all strobes are low. Other behaviours only the bench's scenarios can show: the split of one code over two writes, the dropping of the upper data bits on a nibble write, an untouched input register revealed by a later transfer, the 000 hex that a post-clear transfer moves out, and the exact three-edge latency from pin to output.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Synchronized host controls; strobes are active low.
  typedef struct packed {
    logic clr_n;
    logic sel_n;
    logic wr_n;
    logic xfer_n;
    logic bip;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{clr_n: 1'b1, sel_n: 1'b1, wr_n: 1'b1,
                                  xfer_n: 1'b1, bip: 1'b0};
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1
) (
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] addr,
  output logic              clr_act,
  output logic              bip_zero,
  output logic [NUM_CH-1:0] lo_we,
  output logic [NUM_CH-1:0] hi_we,
  output logic              xfer_en
);
  logic live;

  assign clr_act  = ~ctrl.clr_n;
  assign bip_zero = ctrl.bip;
  assign live     = ctrl.clr_n & ~ctrl.sel_n;
  assign xfer_en  = live & ~ctrl.xfer_n;

  // addr[0] picks the half, the upper bits pick the channel
  always_comb begin
    lo_we = '0;
    hi_we = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (live && !ctrl.wr_n && addr[ADDR_W-1:1] == CH_W'(c)) begin
        if (addr[0]) hi_we[c] = 1'b1;
        else         lo_we[c] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dacfe_channel.sv
module dacfe_channel #(
  parameter int CODE_W = 12,
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_act,
  input  logic              bip_zero,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic              xfer_en,
  input  logic [PORT_W-1:0] data,
  output logic [CODE_W-1:0] code
);
  localparam int              HI_W = CODE_W - PORT_W;
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] in_q, in_nxt;
  logic [CODE_W-1:0] dac_q, dac_nxt;
  logic              in_en, dac_en;

  // input register: low byte and high nibble written separately
  always_comb begin
    in_nxt = in_q;
    if (lo_we)   in_nxt[PORT_W-1:0]      = data;
    if (hi_we)   in_nxt[CODE_W-1:PORT_W] = data[HI_W-1:0];
    if (clr_act) in_nxt = '0;
  end

  // output register takes the input value of this same cycle, which
  // gives pass-through when write and transfer are active together
  always_comb begin
    dac_nxt = dac_q;
    if (xfer_en) dac_nxt = in_nxt;
    if (clr_act) dac_nxt = bip_zero ? MID : '0;
  end

  assign in_en  = clr_act | lo_we | hi_we;
  assign dac_en = clr_act | xfer_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else begin
      if (in_en)  in_q  <= in_nxt;
      if (dac_en) dac_q <= dac_nxt;
    end
  end

  assign code = dac_q;
endmodule

// File: rtl/dac_pair_frontend.sv
module dac_pair_frontend
  import dacfe_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int CODE_W      = 12,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_CH) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PORT_W-1:0]        port_data,
  input  logic [ADDR_W-1:0]        port_addr,
  input  logic                     sel_n,
  input  logic                     wr_n,
  input  logic                     ld_n,
  input  logic                     clr_n,
  input  logic                     bip_mode,
  output logic [NUM_CH*CODE_W-1:0] dac_codes
);
  localparam int BUS_W = ADDR_W + PORT_W;

  ctrl_t              ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]   bus_s;
  logic [ADDR_W-1:0]  addr_s;
  logic [PORT_W-1:0]  data_s;
  logic               clr_act, bip_zero, xfer_en;
  logic [NUM_CH-1:0]  lo_we, hi_we;

  assign ctrl_raw = '{clr_n: clr_n, sel_n: sel_n, wr_n: wr_n,
                      xfer_n: ld_n, bip: bip_mode};

  dacfe_sync #(.W($bits(ctrl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ctrl_raw),
    .dout (ctrl_s)
  );

  // data and address share the strobes' delay so they stay aligned
  dacfe_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({port_addr, port_data}),
    .dout (bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:PORT_W];
  assign data_s = bus_s[PORT_W-1:0];

  dacfe_decode #(.NUM_CH(NUM_CH)) u_decode (
    .ctrl    (ctrl_s),
    .addr    (addr_s),
    .clr_act (clr_act),
    .bip_zero(bip_zero),
    .lo_we   (lo_we),
    .hi_we   (hi_we),
    .xfer_en (xfer_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dacfe_channel #(.CODE_W(CODE_W), .PORT_W(PORT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_act (clr_act),
      .bip_zero(bip_zero),
      .lo_we   (lo_we[c]),
      .hi_we   (hi_we[c]),
      .xfer_en (xfer_en),
      .data    (data_s),
      .code    (dac_codes[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
  import dacfe_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CODE_W = 12,
  parameter int PORT_W = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int HI_W   = CODE_W - PORT_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input ctrl_t                    ctrl_s,
  input logic [ADDR_W-1:0]        addr_s,
  input logic [PORT_W-1:0]        data_s,
  input logic [NUM_CH*CODE_W-1:0] dac_codes
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  // R4: a write without transfer leaves the codes alone
  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s.clr_n && !ctrl_s.sel_n && !ctrl_s.wr_n && ctrl_s.xfer_n)
      |=> $stable(dac_codes));

  // R7: deselected means nothing moves
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_s.clr_n && ctrl_s.sel_n) |=> $stable(dac_codes));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R8 (mode low) and R9 (mode high): clear value depends on mode
    p_clear_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_s.clr_n |=> dac_codes[c*CODE_W +: CODE_W] ==
                        ($past(ctrl_s.bip) ? MID : {CODE_W{1'b0}}));

    // R6: low byte passes straight through
    p_pass_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_s.clr_n && !ctrl_s.sel_n && !ctrl_s.wr_n && !ctrl_s.xfer_n &&
       !addr_s[0] && addr_s[ADDR_W-1:1] == CH_W'(c))
        |=> dac_codes[c*CODE_W +: PORT_W] == $past(data_s));

    // R3: high nibble takes only the lower data bits
    p_pass_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_s.clr_n && !ctrl_s.sel_n && !ctrl_s.wr_n && !ctrl_s.xfer_n &&
       addr_s[0] && addr_s[ADDR_W-1:1] == CH_W'(c))
        |=> dac_codes[c*CODE_W+PORT_W +: HI_W] == $past(data_s[HI_W-1:0]));
  end
endmodule

bind dac_pair_frontend dacfe_checker #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .PORT_W(PORT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_s   (ctrl_s),
  .addr_s   (addr_s),
  .data_s   (data_s),
  .dac_codes(dac_codes)
);

// File: tb/dac_pair_frontend_bench.sv
module dac_pair_frontend_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  port_data;
  logic [1:0]  port_addr;
  logic        sel_n, wr_n, ld_n, clr_n, bip_mode;
  logic [23:0] dac_codes;

  int    checks = 0;
  int    errs   = 0;
  int    cyc    = 0;
  bit    done   = 0;
  string cur_req = "R1";

  typedef struct packed {
    bit       clr_n;
    bit       sel_n;
    bit       wr_n;
    bit       ld_n;
    bit       mode;
    bit [1:0] addr;
    bit [7:0] data;
  } pins_t;

  localparam pins_t IDLE_PINS = '{clr_n: 1, sel_n: 1, wr_n: 1, ld_n: 1,
                                  mode: 0, addr: 0, data: 0};

  pins_t pq[$];
  int    m_in[2];
  int    m_dac[2];

  always #4 clk = ~clk;

  dac_pair_frontend u_dac_pair_frontend (
    .clk(clk), .rst_n(rst_n), .port_data(port_data), .port_addr(port_addr),
    .sel_n(sel_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
    .bip_mode(bip_mode), .dac_codes(dac_codes)
  );

  // reference model: pins take two edges to arrive, applied on the third
  always @(posedge clk) begin
    pins_t e;
    int    ch;
    if (!rst_n) begin
      pq.delete();
      pq.push_back(IDLE_PINS);
      pq.push_back(IDLE_PINS);
      m_in[0] = 0; m_in[1] = 0; m_dac[0] = 0; m_dac[1] = 0;
    end else begin
      e = pq.pop_front();
      if (!e.clr_n) begin
        m_in[0] = 0; m_in[1] = 0;
        m_dac[0] = e.mode ? 2048 : 0;
        m_dac[1] = e.mode ? 2048 : 0;
      end else if (!e.sel_n) begin
        if (!e.wr_n) begin
          ch = int'(e.addr[1]);
          if (e.addr[0]) m_in[ch] = (m_in[ch] & 'hFF) | ((int'(e.data) & 'hF) << 8);
          else           m_in[ch] = (m_in[ch] & 'hF00) | int'(e.data);
        end
        if (!e.ld_n) begin
          m_dac[0] = m_in[0];
          m_dac[1] = m_in[1];
        end
      end
      pq.push_back({clr_n, sel_n, wr_n, ld_n, bip_mode, port_addr, port_data});
    end
  end

  // per-cycle comparison (R12 timing is implied by this alignment)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int c = 0; c < 2; c++) begin
        checks++;
        if (int'(dac_codes[c*12 +: 12]) != m_dac[c]) begin
          errs++;
          $display("FAIL %s per-cycle ch%0d: actual=%h expected=%h",
                   cur_req, c, dac_codes[c*12 +: 12], m_dac[c]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errs++;
      checks++;
      $display("FAIL R12 watchdog: actual=%0d cycles expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic drive(bit s, bit w, bit x, bit c, bit [1:0] a, bit [7:0] d);
    @(negedge clk);
    sel_n = s; wr_n = w; ld_n = x; clr_n = c; port_addr = a; port_data = d;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(bit [1:0] a, bit [7:0] d);
    drive(0, 0, 1, 1, a, d);
    drive(1, 1, 1, 1, a, d);
  endtask

  task automatic transfer();
    drive(0, 1, 0, 1, 0, 0);
    drive(1, 1, 1, 1, 0, 0);
  endtask

  task automatic chk(string req, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1; wr_n = 1; ld_n = 1; clr_n = 1; bip_mode = 0;
    port_addr = 0; port_data = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1", "reset A", dac_codes[11:0], 12'h000);
    chk("R1", "reset B", dac_codes[23:12], 12'h000);

    cur_req = "R2";
    write_reg(2'b00, 8'h5A);
    write_reg(2'b01, 8'hF3);
    write_reg(2'b10, 8'hC7);
    write_reg(2'b11, 8'h09);
    idle(4);
    chk("R4", "write only A", dac_codes[11:0], 12'h000);
    chk("R4", "write only B", dac_codes[23:12], 12'h000);

    cur_req = "R5";
    transfer();
    idle(4);
    chk("R5", "transfer A (R2 R3)", dac_codes[11:0], 12'h35A);
    chk("R5", "transfer B (R2)", dac_codes[23:12], 12'h9C7);

    cur_req = "R7";
    drive(1, 0, 0, 1, 2'b00, 8'h11);
    drive(1, 0, 0, 1, 2'b10, 8'h22);
    drive(1, 1, 1, 1, 0, 0);
    idle(4);
    chk("R7", "deselected A", dac_codes[11:0], 12'h35A);
    transfer();
    idle(4);
    chk("R7", "input A untouched", dac_codes[11:0], 12'h35A);
    chk("R7", "input B untouched", dac_codes[23:12], 12'h9C7);

    cur_req = "R6";
    drive(0, 0, 0, 1, 2'b10, 8'h3C);
    drive(0, 0, 0, 1, 2'b01, 8'hA6);
    drive(1, 1, 1, 1, 0, 0);
    idle(4);
    chk("R6", "transparent B low", dac_codes[23:12], 12'h93C);
    chk("R6", "transparent A high (R3)", dac_codes[11:0], 12'h65A);

    cur_req = "R10";
    bip_mode = 1;
    drive(0, 0, 0, 0, 2'b00, 8'hFF);
    idle(4);
    chk("R10", "clear beats strobes A (R9)", dac_codes[11:0], 12'h800);
    chk("R9", "bipolar clear B", dac_codes[23:12], 12'h800);
    cur_req = "R9";
    drive(1, 1, 1, 1, 0, 0);
    idle(4);
    chk("R9", "held after release", dac_codes[11:0], 12'h800);
    cur_req = "R11";
    transfer();
    idle(4);
    chk("R11", "post-clear transfer A", dac_codes[11:0], 12'h000);
    chk("R11", "post-clear transfer B", dac_codes[23:12], 12'h000);

    cur_req = "R8";
    bip_mode = 0;
    drive(0, 0, 0, 1, 2'b00, 8'h12);
    drive(1, 1, 1, 1, 0, 0);
    idle(4);
    chk("R8", "preload A", dac_codes[11:0], 12'h012);
    drive(1, 1, 1, 0, 0, 0);
    idle(4);
    chk("R8", "unipolar clear A", dac_codes[11:0], 12'h000);
    drive(1, 1, 1, 1, 0, 0);
    transfer();
    idle(4);
    chk("R8", "input cleared A", dac_codes[11:0], 12'h000);

    cur_req = "R12";
    write_reg(2'b10, 8'h44);
    idle(4);
    drive(0, 1, 0, 1, 0, 0);
    @(negedge clk);
    chk("R12", "edge 1 B", dac_codes[23:12], 12'h000);
    sel_n = 1; ld_n = 1;
    @(negedge clk);
    chk("R12", "edge 2 B", dac_codes[23:12], 12'h000);
    @(negedge clk);
    chk("R12", "edge 3 B", dac_codes[23:12], 12'h044);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule